// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU With Flags

This block is the combinational datapath arithmetic unit of a small accumulator processor. It takes two 8-bit accumulators, A and B, a memory operand and the incoming condition flags. In the same cycle it returns the new values of both accumulators and the updated carry, overflow, zero, negative and half-carry flags. A and B can also act as one 16-bit double accumulator, with A as the high byte and B as the low byte. The double accumulator is used by the wide add, wide subtract, wide shifts and the multiply.

An operation code picks the function. A one-bit target select decides whether a byte-wide operation works on A or on B. The accumulator that is not the target comes out unchanged. Decimal adjust always works on A. Instruction decode, operand fetch and write-back sequencing belong to the surrounding core. The core writes `new_a`, `new_b` and the flags back into its registers.

Top module: `alu8_core`

## Requirements
- R1: Operation codes are ADD=0, ADC=1, SUB=2, SBC=3, NEG=4, INC=5, DEC=6, AND=7, OR=8, XOR=9, COM=10, ASL=11, ASR=12, LSR=13, ROL=14, ROR=15, DAA=16, MUL=17, ADDW=18, SUBW=19, ASLW=20, LSRW=21. A byte operation writes A when `sel_b`=0 and B when `sel_b`=1, and leaves the other accumulator unchanged. Codes 22 to 31 leave A, B and every flag unchanged.
- R2: ADD returns operand plus the low memory byte, and ADC also adds `c_in`. Carry is the carry out of bit 7, half-carry is the carry out of bit 3, and overflow flags a signed overflow.
- R3: SUB returns operand minus the low memory byte, and SBC also subtracts `c_in`. Carry is set on a borrow, and overflow flags a signed overflow.
- R4: NEG returns the twos complement, with carry set when the result is nonzero and overflow set when the result is 0x80. COM inverts every bit, sets carry and clears overflow.
- R5: INC and DEC keep `c_in`. Overflow is set when INC gives 0x80 or DEC gives 0x7F.
- R6: AND, OR and XOR combine the operand with the low memory byte. They clear overflow and keep `c_in`.
- R7: ASL and LSR shift one place, and the vacated bit becomes 0. ASR keeps bit 7. Carry takes the bit shifted out, and overflow is negative XOR carry.
- R8: ROL and ROR shift `c_in` into the vacated end and send the bit shifted out to carry. Overflow is negative XOR carry.
- R9: DAA works on A whatever `sel_b` is. It adds 0x06 when `h_in` is set or the low nibble is above 9. It adds 0x60, and sets carry, when `c_in` is set or A is above 0x99; otherwise carry is cleared. Overflow is cleared.
- R10: MUL writes the unsigned product of A and B into A:B. Carry is bit 7 of the product and zero reflects all 16 bits. Negative and overflow keep their inputs.
- R11: ADDW and SUBW add or subtract the 16-bit memory operand to or from A:B, with carry as carry or borrow out of bit 15 and overflow as signed overflow. ASLW and LSRW shift A:B one place, with carry as the bit shifted out and overflow as negative XOR carry.
- R12: Apart from MUL and the unassigned codes, negative is the top bit of the result and zero is set when the result is 0. Half-carry keeps `h_in` except on ADD and ADC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 5 | Operation code (see R1) |
| sel_b | input | 1 | Byte operations target B when 1, A when 0 |
| acc_a | input | 8 | Current accumulator A (high byte of A:B) |
| acc_b | input | 8 | Current accumulator B (low byte of A:B) |
| mem_opnd | input | 16 | Memory operand; bits 7:0 for byte operations |
| c_in | input | 1 | Current carry flag |
| v_in | input | 1 | Current overflow flag |
| z_in | input | 1 | Current zero flag |
| n_in | input | 1 | Current negative flag |
| h_in | input | 1 | Current half-carry flag |
| new_a | output | 8 | Next value of A |
| new_b | output | 8 | Next value of B |
| c_out | output | 1 | Next carry flag |
| v_out | output | 1 | Next overflow flag |
| z_out | output | 1 | Next zero flag |
| n_out | output | 1 | Next negative flag |
| h_out | output | 1 | Next half-carry flag |

## Verification
Every output is a pure function of the current inputs, so each result is due in the same cycle as its stimulus, with no register in the path. The bench applies each operand set on a rising edge and compares all seven outputs on the falling edge half a period later. By then the logic has settled and no new stimulus has been applied. Directed vectors cover the flag corner values: 0x7F/0x80 overflow, zero results, DAA carry, the largest product and 16-bit wrap. Seeded random vectors cover the rest, including the unassigned codes.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBC  = 5'd3,
    OP_NEG  = 5'd4,
    OP_INC  = 5'd5,
    OP_DEC  = 5'd6,
    OP_AND  = 5'd7,
    OP_OR   = 5'd8,
    OP_XOR  = 5'd9,
    OP_COM  = 5'd10,
    OP_ASL  = 5'd11,
    OP_ASR  = 5'd12,
    OP_LSR  = 5'd13,
    OP_ROL  = 5'd14,
    OP_ROR  = 5'd15,
    OP_DAA  = 5'd16,
    OP_MUL  = 5'd17,
    OP_ADDW = 5'd18,
    OP_SUBW = 5'd19,
    OP_ASLW = 5'd20,
    OP_LSRW = 5'd21
  } alu_op_e;

  localparam int OP_BITS = 5;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   m,
  input  logic           c_in,
  input  logic           h_in,
  output logic [W-1:0]   r,
  output logic           c_o,
  output logic           v_o,
  output logic           h_o,
  output logic           hit
);
  localparam logic [W-1:0] TOP_ONLY = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] TOP_MAX  = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] DEC_LIM  = W'(8'h99);

  function automatic logic [W:0] add_ci(input logic [W-1:0] p, input logic [W-1:0] q,
                                        input logic ci);
    return {1'b0, p} + {1'b0, q} + {{W{1'b0}}, ci};
  endfunction

  function automatic logic nib_carry(input logic [3:0] p, input logic [3:0] q, input logic ci);
    logic [4:0] t;
    t = {1'b0, p} + {1'b0, q} + {4'd0, ci};
    return t[4];
  endfunction

  logic [W:0]   sum;
  logic         cin_use;
  logic         lo_fix;
  logic         hi_fix;
  logic [W-1:0] dcor;

  always_comb begin
    sum     = '0;
    r       = x;
    c_o     = c_in;
    v_o     = 1'b0;
    h_o     = h_in;
    hit     = 1'b1;
    cin_use = 1'b0;
    lo_fix  = 1'b0;
    hi_fix  = 1'b0;
    dcor    = '0;
    case (op)
      OP_ADD, OP_ADC: begin
        cin_use = (op == OP_ADC) & c_in;
        sum     = add_ci(x, m, cin_use);
        r       = sum[W-1:0];
        c_o     = sum[W];
        h_o     = nib_carry(x[3:0], m[3:0], cin_use);
        v_o     = (x[W-1] == m[W-1]) && (r[W-1] != x[W-1]);
      end
      OP_SUB, OP_SBC: begin
        cin_use = (op == OP_SBC) & c_in;
        sum     = add_ci(x, ~m, ~cin_use);
        r       = sum[W-1:0];
        c_o     = ~sum[W];
        v_o     = (x[W-1] != m[W-1]) && (r[W-1] != x[W-1]);
      end
      OP_NEG: begin
        sum = add_ci(~x, '0, 1'b1);
        r   = sum[W-1:0];
        c_o = |r;
        v_o = (r == TOP_ONLY);
      end
      OP_INC: begin
        sum = add_ci(x, '0, 1'b1);
        r   = sum[W-1:0];
        v_o = (r == TOP_ONLY);
      end
      OP_DEC: begin
        sum = add_ci(x, '1, 1'b0);
        r   = sum[W-1:0];
        v_o = (r == TOP_MAX);
      end
      OP_DAA: begin
        lo_fix = h_in || (x[3:0] > 4'd9);
        hi_fix = c_in || (x > DEC_LIM);
        dcor   = W'({hi_fix ? 4'h6 : 4'h0, lo_fix ? 4'h6 : 4'h0});
        sum    = add_ci(x, dcor, 1'b0);
        r      = sum[W-1:0];
        c_o    = hi_fix;
      end
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu8_logsh.sv
module alu8_logsh
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   m,
  input  logic           c_in,
  output logic [W-1:0]   r,
  output logic           c_o,
  output logic           v_o,
  output logic           hit
);
  logic is_shift;

  always_comb begin
    r        = x;
    c_o      = c_in;
    hit      = 1'b1;
    is_shift = 1'b0;
    case (op)
      OP_AND: r = x & m;
      OP_OR:  r = x | m;
      OP_XOR: r = x ^ m;
      OP_COM: begin
        r   = ~x;
        c_o = 1'b1;
      end
      OP_ASL: begin
        {c_o, r} = {x, 1'b0};
        is_shift = 1'b1;
      end
      OP_ROL: begin
        {c_o, r} = {x, c_in};
        is_shift = 1'b1;
      end
      OP_LSR: begin
        {r, c_o} = {1'b0, x};
        is_shift = 1'b1;
      end
      OP_ASR: begin
        {r, c_o} = {x[W-1], x};
        is_shift = 1'b1;
      end
      OP_ROR: begin
        {r, c_o} = {c_in, x};
        is_shift = 1'b1;
      end
      default: hit = 1'b0;
    endcase
    v_o = is_shift & (r[W-1] ^ c_o);
  end
endmodule

// File: rtl/alu8_wide.sv
module alu8_wide
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e          op,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic [2*W-1:0]   m,
  output logic [2*W-1:0]   rw,
  output logic             c_o,
  output logic             v_o,
  output logic             keep_nv,
  output logic             hit
);
  localparam int DW = 2 * W;

  function automatic logic [DW-1:0] umul(input logic [W-1:0] p, input logic [W-1:0] q);
    return DW'(p) * DW'(q);
  endfunction

  logic [DW-1:0] d;
  logic [DW:0]   sum;

  assign d = {a, b};

  always_comb begin
    rw      = d;
    sum     = '0;
    c_o     = 1'b0;
    v_o     = 1'b0;
    keep_nv = 1'b0;
    hit     = 1'b1;
    case (op)
      OP_MUL: begin
        rw      = umul(a, b);
        c_o     = rw[W-1];
        keep_nv = 1'b1;
      end
      OP_ADDW: begin
        sum = {1'b0, d} + {1'b0, m};
        rw  = sum[DW-1:0];
        c_o = sum[DW];
        v_o = (d[DW-1] == m[DW-1]) && (rw[DW-1] != d[DW-1]);
      end
      OP_SUBW: begin
        sum = {1'b0, d} + {1'b0, ~m} + {{DW{1'b0}}, 1'b1};
        rw  = sum[DW-1:0];
        c_o = ~sum[DW];
        v_o = (d[DW-1] != m[DW-1]) && (rw[DW-1] != d[DW-1]);
      end
      OP_ASLW: begin
        {c_o, rw} = {d, 1'b0};
        v_o       = rw[DW-1] ^ c_o;
      end
      OP_LSRW: begin
        {rw, c_o} = {1'b0, d};
        v_o       = rw[DW-1] ^ c_o;
      end
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [4:0]     op_sel,
  input  logic           sel_b,
  input  logic [W-1:0]   acc_a,
  input  logic [W-1:0]   acc_b,
  input  logic [2*W-1:0] mem_opnd,
  input  logic           c_in,
  input  logic           v_in,
  input  logic           z_in,
  input  logic           n_in,
  input  logic           h_in,
  output logic [W-1:0]   new_a,
  output logic [W-1:0]   new_b,
  output logic           c_out,
  output logic           v_out,
  output logic           z_out,
  output logic           n_out,
  output logic           h_out
);
  localparam int DW = 2 * W;

  alu_op_e      op;
  logic         to_a;
  logic [W-1:0] x_opnd;
  logic [W-1:0] m_byte;

  logic [W-1:0] arith_res, logic_res, narrow_res;
  logic         arith_c, arith_v, arith_h, arith_hit;
  logic         logic_c, logic_v, logic_hit;
  logic [DW-1:0] wide_res;
  logic         wide_c, wide_v, wide_keep, wide_hit;

  assign op     = alu_op_e'(op_sel);
  assign to_a   = (op == OP_DAA) || !sel_b;
  assign x_opnd = to_a ? acc_a : acc_b;
  assign m_byte = mem_opnd[W-1:0];

  alu8_arith #(.W(W)) u_arith (
    .op(op), .x(x_opnd), .m(m_byte), .c_in(c_in), .h_in(h_in),
    .r(arith_res), .c_o(arith_c), .v_o(arith_v), .h_o(arith_h), .hit(arith_hit)
  );

  alu8_logsh #(.W(W)) u_logsh (
    .op(op), .x(x_opnd), .m(m_byte), .c_in(c_in),
    .r(logic_res), .c_o(logic_c), .v_o(logic_v), .hit(logic_hit)
  );

  alu8_wide #(.W(W)) u_wide (
    .op(op), .a(acc_a), .b(acc_b), .m(mem_opnd),
    .rw(wide_res), .c_o(wide_c), .v_o(wide_v), .keep_nv(wide_keep), .hit(wide_hit)
  );

  assign narrow_res = arith_hit ? arith_res : logic_res;

  always_comb begin
    new_a = acc_a;
    new_b = acc_b;
    c_out = c_in;
    v_out = v_in;
    z_out = z_in;
    n_out = n_in;
    h_out = h_in;
    if (wide_hit) begin
      {new_a, new_b} = wide_res;
      c_out = wide_c;
      v_out = wide_keep ? v_in : wide_v;
      n_out = wide_keep ? n_in : wide_res[DW-1];
      z_out = (wide_res == '0);
    end else if (arith_hit || logic_hit) begin
      if (to_a) new_a = narrow_res;
      else      new_b = narrow_res;
      c_out = arith_hit ? arith_c : logic_c;
      v_out = arith_hit ? arith_v : logic_v;
      h_out = arith_hit ? arith_h : h_in;
      n_out = narrow_res[W-1];
      z_out = (narrow_res == '0);
    end
  end
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input logic [4:0]     op_sel,
  input logic           sel_b,
  input logic [W-1:0]   acc_a,
  input logic [W-1:0]   acc_b,
  input logic [2*W-1:0] mem_opnd,
  input logic           c_in,
  input logic           h_in,
  input logic [W-1:0]   new_a,
  input logic [W-1:0]   new_b,
  input logic           c_out,
  input logic           v_out,
  input logic           n_out,
  input logic           h_out,
  input logic           arith_hit,
  input logic           logic_hit,
  input logic           wide_hit
);
  logic is_shift, keeps_c, narrow_op;

  always_comb begin
    is_shift  = op_sel inside {OP_ASL, OP_ASR, OP_LSR, OP_ROL, OP_ROR, OP_ASLW, OP_LSRW};
    keeps_c   = op_sel inside {OP_INC, OP_DEC, OP_AND, OP_OR, OP_XOR};
    narrow_op = (arith_hit || logic_hit) && (op_sel != OP_DAA);

    p_one_unit_r1: assert ($onehot0({arith_hit, logic_hit, wide_hit}))
      else $error("more than one unit claimed the operation");

    if (narrow_op) begin
      p_other_acc_r1: assert (sel_b ? (new_a == acc_a) : (new_b == acc_b))
        else $error("non-target accumulator changed");
    end

    if (op_sel == OP_ADD && !sel_b) begin
      p_add_sum_r2: assert ({c_out, new_a} == ({1'b0, acc_a} + {1'b0, mem_opnd[W-1:0]}))
        else $error("byte add result mismatch");
    end

    if (keeps_c) begin
      p_carry_kept_r5: assert (c_out == c_in)
        else $error("carry changed by an operation that keeps it");
    end

    if (is_shift) begin
      p_shift_ovf_r7: assert (v_out == (n_out ^ c_out))
        else $error("shift overflow is not N xor C");
    end

    if (op_sel == OP_MUL) begin
      p_mul_prod_r10: assert ({new_a, new_b} == ((2*W)'(acc_a) * (2*W)'(acc_b)))
        else $error("product mismatch");
    end

    if (op_sel != OP_ADD && op_sel != OP_ADC) begin
      p_half_kept_r12: assert (h_out == h_in)
        else $error("half-carry changed outside add");
    end
  end
endmodule

bind alu8_core alu8_core_chk #(.W(W)) u_chk (
  .op_sel(op_sel), .sel_b(sel_b), .acc_a(acc_a), .acc_b(acc_b), .mem_opnd(mem_opnd),
  .c_in(c_in), .h_in(h_in), .new_a(new_a), .new_b(new_b), .c_out(c_out),
  .v_out(v_out), .n_out(n_out), .h_out(h_out),
  .arith_hit(arith_hit), .logic_hit(logic_hit), .wide_hit(wide_hit)
);

// File: tb/alu8_core_test.sv
`timescale 1ns/1ps
module alu8_core_test;
  localparam int CLK_NS = 20;

  logic clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic [4:0]  op_sel = '0;
  logic        sel_b = 1'b0;
  logic [7:0]  acc_a = '0, acc_b = '0;
  logic [15:0] mem_opnd = '0;
  logic        c_in = 1'b0, v_in = 1'b0, z_in = 1'b0, n_in = 1'b0, h_in = 1'b0;
  logic [7:0]  new_a, new_b;
  logic        c_out, v_out, z_out, n_out, h_out;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  alu8_core uut (
    .op_sel(op_sel), .sel_b(sel_b), .acc_a(acc_a), .acc_b(acc_b), .mem_opnd(mem_opnd),
    .c_in(c_in), .v_in(v_in), .z_in(z_in), .n_in(n_in), .h_in(h_in),
    .new_a(new_a), .new_b(new_b), .c_out(c_out), .v_out(v_out),
    .z_out(z_out), .n_out(n_out), .h_out(h_out)
  );

  typedef struct packed {
    logic [7:0] a;
    logic [7:0] b;
    logic c, v, z, n, h;
  } exp_t;

  function automatic string tag_of(int op);
    if (op <= 1) return "R2";
    if (op <= 3) return "R3";
    if (op == 4 || op == 10) return "R4";
    if (op <= 6) return "R5";
    if (op <= 9) return "R6";
    if (op <= 13) return "R7";
    if (op <= 15) return "R8";
    if (op == 16) return "R9";
    if (op == 17) return "R10";
    if (op <= 21) return "R11";
    return "R1";
  endfunction

  function automatic exp_t model(int op, bit sel, int a, int b, int m,
                                 bit ci, bit vi, bit zi, bit ni, bit hi);
    exp_t e;
    int x, ml, r, s, d, cc, cor;
    bit byte_op;
    e = '{a: a[7:0], b: b[7:0], c: ci, v: vi, z: zi, n: ni, h: hi};
    x = (sel && op != 16) ? b : a;
    ml = m & 255;
    r = 0;
    byte_op = 1'b1;
    case (op)
      0, 1: begin
        cc = (op == 1) ? int'(ci) : 0;
        s = x + ml + cc; r = s & 255; e.c = (s > 255);
        e.h = ((x & 15) + (ml & 15) + cc) > 15;
        e.v = (((x ^ r) & (ml ^ r) & 128) != 0);
      end
      2, 3: begin
        cc = (op == 3) ? int'(ci) : 0;
        s = x - ml - cc; r = s & 255; e.c = (s < 0);
        e.v = (((x ^ ml) & (x ^ r) & 128) != 0);
      end
      4: begin r = (256 - x) & 255; e.c = (r != 0); e.v = (r == 128); end
      5: begin r = (x + 1) & 255; e.v = (r == 128); end
      6: begin r = (x + 255) & 255; e.v = (r == 127); end
      7: begin r = x & ml; e.v = 1'b0; end
      8: begin r = x | ml; e.v = 1'b0; end
      9: begin r = x ^ ml; e.v = 1'b0; end
      10: begin r = 255 - x; e.c = 1'b1; e.v = 1'b0; end
      11: begin r = (x * 2) & 255; e.c = (x >= 128); end
      12: begin r = (x / 2) | (x & 128); e.c = x[0]; end
      13: begin r = x / 2; e.c = x[0]; end
      14: begin r = (x * 2 + int'(ci)) & 255; e.c = (x >= 128); end
      15: begin r = x / 2 + (ci ? 128 : 0); e.c = x[0]; end
      16: begin
        cor = 0;
        if (hi || (x % 16) > 9) cor = 6;
        if (ci || x > 153) begin cor = cor + 96; e.c = 1'b1; end
        else e.c = 1'b0;
        r = (x + cor) & 255; e.v = 1'b0;
      end
      17: begin
        byte_op = 1'b0;
        s = a * b;
        e.a = s[15:8]; e.b = s[7:0]; e.c = s[7]; e.z = (s == 0);
      end
      18, 19, 20, 21: begin
        byte_op = 1'b0;
        d = a * 256 + b;
        if (op == 18) begin
          s = d + m; r = s & 65535; e.c = (s > 65535);
          e.v = (((d ^ r) & (m ^ r) & 32768) != 0);
        end else if (op == 19) begin
          s = d - m; r = s & 65535; e.c = (s < 0);
          e.v = (((d ^ m) & (d ^ r) & 32768) != 0);
        end else if (op == 20) begin
          r = (d * 2) & 65535; e.c = (d >= 32768);
          e.v = (r >= 32768) ^ e.c;
        end else begin
          r = d / 2; e.c = d[0];
          e.v = (r >= 32768) ^ e.c;
        end
        e.a = r[15:8]; e.b = r[7:0]; e.n = (r >= 32768); e.z = (r == 0);
      end
      default: byte_op = 1'b0;
    endcase
    if (byte_op) begin
      if (op >= 11 && op <= 15) e.v = (r >= 128) ^ e.c;
      if (sel && op != 16) e.b = r[7:0];
      else e.a = r[7:0];
      e.n = (r >= 128);
      e.z = (r == 0);
    end
    return e;
  endfunction

  task automatic apply(input int op, input bit sel, input int a, input int b, input int m,
                       input bit ci, input bit vi, input bit zi, input bit ni, input bit hi,
                       input string req);
    exp_t want, got;
    @(posedge clk);
    op_sel = op[4:0]; sel_b = sel; acc_a = a[7:0]; acc_b = b[7:0]; mem_opnd = m[15:0];
    c_in = ci; v_in = vi; z_in = zi; n_in = ni; h_in = hi;
    want = model(op, sel, a & 255, b & 255, m & 65535, ci, vi, zi, ni, hi);
    @(negedge clk);
    got = '{a: new_a, b: new_b, c: c_out, v: v_out, z: z_out, n: n_out, h: h_out};
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s op=%0d sel=%0d a=%02h b=%02h m=%04h: got A=%02h B=%02h CVZNH=%b%b%b%b%b expected A=%02h B=%02h CVZNH=%b%b%b%b%b",
               req, op, sel, a & 255, b & 255, m & 65535,
               got.a, got.b, got.c, got.v, got.z, got.n, got.h,
               want.a, want.b, want.c, want.v, want.z, want.n, want.h);
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // idle state: all-zero inputs give zero result, R12 zero flag set
    apply(0, 0, 8'h00, 8'h00, 0, 0, 0, 0, 0, 0, "R12");
    // R1: target select and untouched accumulator, unassigned code
    apply(0, 1, 8'h12, 8'h34, 16'h0011, 0, 0, 0, 0, 0, "R1");
    apply(25, 1, 8'hA5, 8'h5A, 16'hFFFF, 1, 1, 1, 1, 1, "R1");
    apply(31, 0, 8'h00, 8'h80, 16'h1234, 0, 1, 0, 1, 0, "R1");
    // R2: signed overflow, carry with carry-in, half-carry
    apply(0, 0, 8'h7F, 8'h00, 16'h0001, 0, 0, 0, 0, 0, "R2");
    apply(1, 0, 8'hFF, 8'h00, 16'h0000, 1, 0, 0, 0, 0, "R2");
    apply(1, 1, 8'h00, 8'h08, 16'h0008, 0, 0, 0, 0, 1, "R2");
    // R3: borrow and overflow
    apply(2, 0, 8'h80, 8'h00, 16'h0001, 0, 0, 0, 0, 0, "R3");
    apply(3, 1, 8'h00, 8'h05, 16'h0005, 1, 0, 0, 0, 0, "R3");
    // R4: negate of 0x80 and 0, complement
    apply(4, 0, 8'h80, 8'h00, 0, 0, 0, 0, 0, 0, "R4");
    apply(4, 0, 8'h00, 8'h00, 0, 1, 1, 0, 0, 0, "R4");
    apply(10, 1, 8'h00, 8'hF0, 0, 0, 1, 0, 0, 0, "R4");
    // R5: increment to 0x80, decrement to 0x7F, carry kept
    apply(5, 0, 8'h7F, 8'h00, 0, 1, 0, 0, 0, 0, "R5");
    apply(6, 1, 8'h00, 8'h80, 0, 1, 0, 0, 0, 0, "R5");
    apply(5, 0, 8'hFF, 8'h00, 0, 0, 0, 0, 0, 0, "R5");
    // R6: logic keeps carry, clears overflow
    apply(7, 0, 8'hF0, 8'h00, 16'h000F, 1, 1, 0, 0, 0, "R6");
    apply(9, 1, 8'h00, 8'hAA, 16'h0055, 0, 1, 0, 0, 0, "R6");
    // R7: shifts
    apply(12, 0, 8'h81, 8'h00, 0, 0, 0, 0, 0, 0, "R7");
    apply(11, 0, 8'h40, 8'h00, 0, 0, 0, 0, 0, 0, "R7");
    apply(13, 1, 8'h00, 8'h01, 0, 0, 0, 0, 0, 0, "R7");
    // R8: rotates through carry
    apply(15, 0, 8'h02, 8'h00, 0, 1, 0, 0, 0, 0, "R8");
    apply(14, 1, 8'h00, 8'h80, 0, 0, 0, 0, 0, 0, "R8");
    // R9: decimal adjust corners
    apply(16, 1, 8'h9A, 8'h11, 0, 0, 0, 0, 0, 0, "R9");
    apply(16, 0, 8'h12, 8'h00, 0, 0, 0, 0, 0, 1, "R9");
    apply(16, 0, 8'h45, 8'h00, 0, 0, 1, 0, 0, 0, "R9");
    apply(16, 0, 8'h20, 8'h00, 0, 1, 0, 0, 0, 0, "R9");
    // R10: multiply extremes
    apply(17, 0, 8'hFF, 8'hFF, 0, 0, 1, 0, 1, 0, "R10");
    apply(17, 1, 8'h00, 8'h37, 0, 1, 0, 0, 0, 0, "R10");
    apply(17, 0, 8'h10, 8'h08, 0, 0, 0, 1, 0, 0, "R10");
    // R11: wide ops
    apply(18, 0, 8'hFF, 8'hFF, 16'h0001, 0, 0, 0, 0, 0, "R11");
    apply(18, 0, 8'h7F, 8'hFF, 16'h0001, 0, 0, 0, 0, 0, "R11");
    apply(19, 0, 8'h00, 8'h00, 16'h0001, 0, 0, 0, 0, 0, "R11");
    apply(20, 0, 8'h80, 8'h00, 0, 0, 0, 0, 0, 0, "R11");
    apply(21, 0, 8'h00, 8'h01, 0, 0, 0, 0, 0, 0, "R11");
    // random mix over all 32 codes
    for (int i = 0; i < 4000; i++) begin
      int op;
      op = int'($urandom_range(0, 31));
      apply(op, bit'($urandom_range(0, 1)), int'($urandom_range(0, 255)),
            int'($urandom_range(0, 255)), int'($urandom_range(0, 65535)),
            bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
            bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
            bit'($urandom_range(0, 1)), tag_of(op));
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule